// File: doc/BRIEF.md
# Synchronous One-Shot Pulse Generator

This block turns the rising edge of an asynchronous trigger signal into a single output pulse. The pulse lasts a programmed number of system-clock cycles and then ends without further input. When no pulse is running, the block rests in its only stable state. It provides a true output and an inverted output. The pulse length comes from a runtime duration input, whose width is set by a parameter. The value is sampled at the moment the pulse starts, so a pulse is not affected by later changes to the duration input or by how long the trigger stays high.

A mode input chooses what happens when a trigger edge arrives while a pulse is running. In one-shot mode the edge is dropped, and the block must return to rest before it can fire again. In retrigger mode the edge restarts a full interval, so the output stays high until a whole interval has passed since the last edge. The trigger first passes through a two-stage synchronizer and then through a rising-edge detector. Because of this, the block can be driven from any clock domain, or from a switch that has already been debounced.

Top module: `os_pulse_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block is forced to rest after that edge: `q` = 0 and `q_n` = 1, with no pulse pending and the edge detector history cleared.
- R2: Only a 0-to-1 change of `trig_in` starts a pulse. If `trig_in` rises before clock edge k, `q` is high after edge k+2 and not before it. A falling trigger starts nothing.
- R3: The pulse stays high for exactly the value of `duration` sampled when the pulse started. This holds however long `trig_in` stays high and however `duration` changes during the pulse.
- R4: A sampled `duration` of 0 gives a pulse of exactly one cycle.
- R5: With `retrig_mode` = 0 (one-shot), a trigger edge that arrives while a pulse is running has no effect. This includes an edge in the pulse's final cycle, and no second pulse follows.
- R6: With `retrig_mode` = 1 (retrigger), each trigger edge during a pulse reloads a full interval. An edge in the final cycle extends the pulse with no low cycle in between.
- R7: A pulse can only be restarted if it was started in retrigger mode and `retrig_mode` is 1 when the new edge arrives. A change of mode therefore never extends a pulse already running.
- R8: `q_n` is the inverse of `q` in every cycle.
- R9: When a pulse's interval runs out with no restart, `q` returns to 0 on its own on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_in | input | 1 | Asynchronous trigger; its rising edge fires a pulse |
| retrig_mode | input | 1 | 0 = one-shot (edges during a pulse are ignored), 1 = retrigger |
| duration | input | DUR_W | Pulse length in cycles, sampled when a pulse starts; 0 means 1 |
| q | output | 1 | True output, high during the pulse |
| q_n | output | 1 | Inverted output, low during the pulse |

## Verification
On every cycle, the assertions check five things:
- the rest state after reset;
- that the two outputs are complementary;
- that a pulse never begins without a detected edge;
- that the countdown is untouched by edges in one-shot mode, and that the output stays high after a restart in retrigger mode;
- the one-cycle pulse for a zero duration, and the return to rest when the count expires.

Some behaviour only the bench scenarios can show. These are the exact latency from the trigger pin to the output and the exact length of each pulse. The bench also shows the boundary edges that land in a pulse's final cycle in both modes, the effect of changing mode in the middle of a pulse, and that extra or falling triggers produce no pulse at all.

// File: rtl/os_pkg.sv
`timescale 1ns/1ps
// Shared types for the one-shot pulse generator.
package os_pkg;
    typedef enum logic {
        MODE_ONESHOT = 1'b0,
        MODE_RETRIG  = 1'b1
    } os_mode_e;
endpackage

// File: rtl/os_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for one asynchronous bit.
// Assumes the input is quasi-static compared with the clock period.
module os_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/os_rise.sv
`timescale 1ns/1ps
// Rising-edge detector on a signal that is already synchronous.
// Output is high for one cycle when the sample is 1 and the previous sample was 0.
module os_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic prev;

    // Remember the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= level;
    end

    assign rise = level & ~prev;
endmodule

// File: rtl/os_timer.sv
`timescale 1ns/1ps
// Down-counter holding the pulse interval.
// cnt is nonzero exactly while a pulse is active. A new pulse loads max(duration,1).
// A restart is allowed only when the running pulse began in retrigger mode
// and the mode is still retrigger when the edge arrives.
module os_timer
    import os_pkg::*;
#(
    parameter int DUR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  os_mode_e         mode,
    input  logic [DUR_W-1:0] duration,
    output logic [DUR_W-1:0] cnt,
    output logic [DUR_W-1:0] cnt_nxt,
    output logic             run_retrig
);
    localparam logic [DUR_W-1:0] ONE = DUR_W'(1);

    logic             busy;
    logic             start;
    logic             restart;
    logic [DUR_W-1:0] load_val;

    // Decide start, restart and the next count value.
    always_comb begin
        busy     = (cnt != '0);
        start    = rise && !busy;
        restart  = rise && busy && (mode == MODE_RETRIG) && run_retrig;
        load_val = (duration == '0) ? ONE : duration;
        if (start || restart) cnt_nxt = load_val;
        else if (busy)        cnt_nxt = cnt - ONE;
        else                  cnt_nxt = '0;
    end

    // Update the counter and the mode captured when a pulse starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            run_retrig <= 1'b0;
        end else begin
            cnt <= cnt_nxt;
            if (start) run_retrig <= (mode == MODE_RETRIG);
        end
    end
endmodule

// File: rtl/os_pulse_gen.sv
`timescale 1ns/1ps
// Synchronous one-shot: trigger synchronizer, edge detector, interval timer
// and complementary registered outputs.
// Assumes trig_in may be asynchronous; retrig_mode and duration are synchronous to clk.
module os_pulse_gen
    import os_pkg::*;
#(
    parameter int DUR_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic             retrig_mode,
    input  logic [DUR_W-1:0] duration,
    output logic             q,
    output logic             q_n
);
    logic             trig_s;
    logic             rise;
    logic [DUR_W-1:0] cnt;
    logic [DUR_W-1:0] cnt_nxt;
    logic             run_retrig;
    os_mode_e         mode;

    assign mode = os_mode_e'(retrig_mode);

    os_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trig_in),
        .sync_out (trig_s)
    );

    os_rise u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (trig_s),
        .rise  (rise)
    );

    os_timer #(.DUR_W(DUR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .mode       (mode),
        .duration   (duration),
        .cnt        (cnt),
        .cnt_nxt    (cnt_nxt),
        .run_retrig (run_retrig)
    );

    // Register the true and inverted outputs as separate flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= 1'b0;
            q_n <= 1'b1;
        end else begin
            q   <= (cnt_nxt != '0);
            q_n <= (cnt_nxt == '0);
        end
    end
endmodule

// File: rtl/os_pulse_chk.sv
`timescale 1ns/1ps
// Cycle-level properties of the one-shot, attached to the top module by bind.
module os_pulse_chk #(
    parameter int DUR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             retrig_mode,
    input logic [DUR_W-1:0] duration,
    input logic             q,
    input logic             q_n,
    input logic             rise,
    input logic [DUR_W-1:0] cnt,
    input logic             run_retrig
);
    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!q && q_n)); // R1

    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        q != q_n); // R8

    AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> $past(rise)); // R2

    AST_ONESHOT_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (q && rise && !run_retrig) |=> (cnt == $past(cnt) - DUR_W'(1))); // R5

    AST_RETRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q && rise && retrig_mode && run_retrig) |=> q); // R6

    AST_ZERO_AS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!q && rise && duration == '0) |=> (q ##1 !q)); // R4

    AST_SELF_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (q && cnt == DUR_W'(1) && !rise) |=> !q); // R9
endmodule

bind os_pulse_gen os_pulse_chk #(.DUR_W(DUR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .retrig_mode (retrig_mode),
    .duration    (duration),
    .q           (q),
    .q_n         (q_n),
    .rise        (rise),
    .cnt         (cnt),
    .run_retrig  (run_retrig)
);

// File: tb/sim_os_pulse_gen.sv
`timescale 1ns/1ps
// Scoreboard bench: scenarios push expected pulse lengths, the monitor measures
// each pulse at the outputs and compares it with the head of the queue.
module sim_os_pulse_gen;
    localparam int DUR_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trig_in = 1'b0;
    logic             retrig_mode = 1'b0;
    logic [DUR_W-1:0] duration = '0;
    logic             q;
    logic             q_n;

    int    total = 0;
    int    bad = 0;
    int    inv_bad = 0;
    int    pulses_seen = 0;
    int    pulses_exp = 0;
    int    run_len = 0;
    int    e_len;
    string e_tag;
    bit    prev_q = 1'b0;
    bit    done = 1'b0;
    int    exp_len_q[$];
    string exp_tag_q[$];

    always #4 clk = ~clk;

    os_pulse_gen #(.DUR_W(DUR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .retrig_mode(retrig_mode),
        .duration(duration), .q(q), .q_n(q_n)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_pulse(input int len, input string tag);
        exp_len_q.push_back(len);
        exp_tag_q.push_back(tag);
        pulses_exp++;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire(input int hold, input int low);
        trig_in = 1'b1;
        idle(hold);
        trig_in = 1'b0;
        idle(low);
    endtask

    // Monitor: measure pulse widths at the ports and score them.
    always @(negedge clk) begin
        if (!rst_n) begin
            run_len = 0;
            prev_q  = 1'b0;
        end else begin
            if (q === q_n) inv_bad++;
            if (q) run_len++;
            if (prev_q && !q) begin
                pulses_seen++;
                if (exp_len_q.size() == 0) begin
                    total++;
                    bad++;
                    $display("FAIL R5 unexpected pulse actual=%0d expected=none", run_len);
                end else begin
                    e_len = exp_len_q.pop_front();
                    e_tag = exp_tag_q.pop_front();
                    check({e_tag, " pulse length"}, run_len, e_len);
                end
                run_len = 0;
            end
            prev_q = q;
        end
    end

    initial begin
        // R1 reset state
        idle(3);
        check("R1 q in reset", int'(q), 0);
        check("R1 q_n in reset", int'(q_n), 1);
        rst_n = 1'b1;
        idle(3);

        // R2 latency from trigger pin; R3 duration change mid-pulse ignored
        duration = 8'd5;
        expect_pulse(5, "R3");
        trig_in = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R2 q low after two edges", int'(q), 0);
        @(posedge clk); @(negedge clk);
        check("R2 q high after third edge", int'(q), 1);
        duration = 8'd9;
        trig_in  = 1'b0;
        idle(12);

        // R3 long trigger level; R2 falling edge starts nothing
        duration = 8'd4;
        expect_pulse(4, "R3");
        fire(20, 10);
        check("R2 pulses after long trigger", pulses_seen, pulses_exp);

        // R4 zero duration
        duration = 8'd0;
        expect_pulse(1, "R4");
        fire(1, 8);

        // R5 second edge mid-pulse in one-shot mode
        duration = 8'd10;
        expect_pulse(10, "R5");
        fire(1, 3);
        fire(1, 20);
        check("R5 no extra pulse mid", pulses_seen, pulses_exp);

        // R5 edge in final cycle, one-shot
        duration = 8'd4;
        expect_pulse(4, "R5");
        fire(1, 3);
        fire(1, 12);
        check("R5 no extra pulse final cycle", pulses_seen, pulses_exp);

        // R6 edge in final cycle, retrigger: no gap
        retrig_mode = 1'b1;
        duration = 8'd4;
        expect_pulse(8, "R6");
        fire(1, 3);
        fire(1, 14);

        // R6 train of edges every 4 cycles
        duration = 8'd6;
        expect_pulse(14, "R6");
        fire(2, 2);
        fire(2, 2);
        fire(2, 22);

        // R7 one-shot pulse, switch to retrigger, trigger: not extended
        retrig_mode = 1'b0;
        duration = 8'd10;
        expect_pulse(10, "R7");
        fire(1, 3);
        retrig_mode = 1'b1;
        fire(1, 20);

        // R7 retrigger pulse, switch to one-shot, trigger: ignored
        expect_pulse(10, "R7");
        fire(1, 3);
        retrig_mode = 1'b0;
        fire(1, 20);

        // R9 rests without input; R8 complement; scoreboard drained
        check("R9 q at rest", int'(q), 0);
        check("R9 all pulses ended", pulses_seen, pulses_exp);
        check("R7 queue drained", exp_len_q.size(), 0);
        check("R8 complement mismatches", inv_bad, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule